// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block forms the unsigned product of two W-bit operands, one multiplier bit at a time. Three W-bit registers hold the running high half (accumulator), the multiplier that shifts out as the low half of the product fills in, and the multiplicand. A one-bit carry register sits above the accumulator. In each iteration the accumulator takes the multiplicand if the multiplier's current low bit is set. The whole carry/accumulator/multiplier chain then shifts right by one place. After W iterations the 2W-bit product lies in the accumulator and multiplier registers. The adder is only W bits wide.

A caller pulses `start_i` with both operands present while the block is not busy. `busy_o` stays high for 2W cycles, because each iteration takes one add cycle and one shift cycle. `done_o` then pulses for one cycle and the product stays on `product_o` until the next accepted start. The width W is a parameter with a default of 8.

The controller has four states. **IDLE** waits for work. **ADD** performs the add if the multiplier's low bit is 1. **SHIFT** shifts the chain, clears the carry and counts the iteration. **DONE** flags completion. The transitions are as follows. *accept* goes from IDLE or DONE to ADD on a start. *step* goes from ADD to SHIFT. *next* goes from SHIFT back to ADD while iterations remain. *finish* goes from SHIFT to DONE after the W-th shift. *rest* goes from DONE to IDLE when no start is present.

Top module: `shiftadd_mul`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0 and `product_o` is all zeros.
- R2: A start with `busy_o` low is accepted. `busy_o` is 1 in the cycle after the accepting clock edge, and the operands sampled at that edge are the ones multiplied.
- R3: At `done_o`, `product_o` equals the unsigned product mcand × mplier, zero-extended to 2W bits, for every operand pair.
- R4: `done_o` is first high 2W clock edges after the accepting edge, and `busy_o` is high for exactly the 2W cycles before it.
- R5: `done_o` is high for a single cycle, never together with `busy_o`, and is followed by `busy_o` = 0 unless a new start is accepted.
- R6: A start while `busy_o` is high is ignored. The running operation returns its original result at its original time.
- R7: While the block is not busy and no start is accepted, `product_o` stays unchanged, whatever the operand inputs do.
- R8: Carries out of the accumulator are kept. All-ones times all-ones gives (2^W−1)^2, and a zero operand gives zero.
- R9: With W = 4, 1011 × 1101 gives 10001111 (11 × 13 = 143).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a multiply; honoured only while not busy |
| mcand_i | input | W | Multiplicand operand |
| mplier_i | input | W | Multiplier operand |
| busy_o | output | 1 | Multiply in progress |
| done_o | output | 1 | One-cycle pulse: product valid |
| product_o | output | 2W | Product, high half from accumulator, low half from multiplier register |

## Verification
A wrong add decision, a lost or stale carry, or a misrouted shift bit corrupts `product_o`. The error becomes visible when `done_o` rises, 2W cycles after acceptance. Operand pairs are therefore chosen to make carries frequent: all-ones, exhaustive 4-bit, and random 8-bit. An iteration-count or state error instead moves or repeats the `done_o` pulse, or leaves `busy_o` high. A cycle count from acceptance detects that in the very operation where it happens. An operand register that leaks input changes shows up as a drifting `product_o` during the hold check.

// File: rtl/shiftadd_mul_pkg.sv
package shiftadd_mul_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ADD   = 2'd1,
        ST_SHIFT = 2'd2,
        ST_DONE  = 2'd3
    } mul_state_e;

    typedef struct packed {
        logic load;
        logic add;
        logic shift;
    } dp_ctrl_t;

endpackage

// File: rtl/shiftadd_mul_ctrl.sv
module shiftadd_mul_ctrl
    import shiftadd_mul_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     start_i,
    input  logic     q_lsb_i,
    input  logic     last_i,
    output dp_ctrl_t dp_o,
    output logic     cnt_load_o,
    output logic     cnt_dec_o,
    output logic     busy_o,
    output logic     done_o
);

    mul_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // transitions: accept, step, next, finish, rest
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_ADD;
            ST_ADD:   state_d = ST_SHIFT;
            ST_SHIFT: state_d = last_i ? ST_DONE : ST_ADD;
            ST_DONE:  state_d = start_i ? ST_ADD : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        dp_o       = '0;
        cnt_load_o = 1'b0;
        cnt_dec_o  = 1'b0;
        busy_o     = 1'b0;
        done_o     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                dp_o.load  = start_i;
                cnt_load_o = start_i;
            end
            ST_ADD: begin
                busy_o   = 1'b1;
                dp_o.add = q_lsb_i;
            end
            ST_SHIFT: begin
                busy_o     = 1'b1;
                dp_o.shift = 1'b1;
                cnt_dec_o  = 1'b1;
            end
            ST_DONE: begin
                done_o     = 1'b1;
                dp_o.load  = start_i;
                cnt_load_o = start_i;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/shiftadd_mul_counter.sv
module shiftadd_mul_counter #(
    parameter int W = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    input  logic dec_i,
    output logic last_o
);

    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     cnt_q <= '0;
        else if (load_i) cnt_q <= CW'(W);
        else if (dec_i)  cnt_q <= cnt_q - CW'(1);
    end

    assign last_o = (cnt_q == CW'(1));

endmodule

// File: rtl/shiftadd_mul_datapath.sv
module shiftadd_mul_datapath
    import shiftadd_mul_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  dp_ctrl_t       ctl_i,
    input  logic [W-1:0]   mcand_i,
    input  logic [W-1:0]   mplier_i,
    output logic           q_lsb_o,
    output logic [2*W-1:0] product_o
);

    logic [W-1:0] acc_q;
    logic [W-1:0] mq_q;
    logic [W-1:0] mcand_q;
    logic         carry_q;
    logic [W:0]   sum;

    assign sum = {1'b0, acc_q} + {1'b0, mcand_q};

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            acc_q   <= '0;
            mq_q    <= '0;
            mcand_q <= '0;
            carry_q <= 1'b0;
        end else if (ctl_i.load) begin
            acc_q   <= '0;
            carry_q <= 1'b0;
            mq_q    <= mplier_i;
            mcand_q <= mcand_i;
        end else if (ctl_i.add) begin
            {carry_q, acc_q} <= sum;
        end else if (ctl_i.shift) begin
            // carry enters accumulator top, accumulator lsb enters multiplier top
            {carry_q, acc_q, mq_q} <= {1'b0, carry_q, acc_q, mq_q[W-1:1]};
        end
    end

    assign q_lsb_o   = mq_q[0];
    assign product_o = {acc_q, mq_q};

endmodule

// File: rtl/shiftadd_mul.sv
module shiftadd_mul
    import shiftadd_mul_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           start_i,
    input  logic [W-1:0]   mcand_i,
    input  logic [W-1:0]   mplier_i,
    output logic           busy_o,
    output logic           done_o,
    output logic [2*W-1:0] product_o
);

    dp_ctrl_t dp_ctl;
    logic     q_lsb;
    logic     last;
    logic     cnt_load;
    logic     cnt_dec;

    shiftadd_mul_ctrl u_ctrl (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (start_i),
        .q_lsb_i    (q_lsb),
        .last_i     (last),
        .dp_o       (dp_ctl),
        .cnt_load_o (cnt_load),
        .cnt_dec_o  (cnt_dec),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    shiftadd_mul_counter #(.W(W)) u_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (cnt_load),
        .dec_i  (cnt_dec),
        .last_o (last)
    );

    shiftadd_mul_datapath #(.W(W)) u_dp (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .ctl_i     (dp_ctl),
        .mcand_i   (mcand_i),
        .mplier_i  (mplier_i),
        .q_lsb_o   (q_lsb),
        .product_o (product_o)
    );

endmodule

// File: rtl/shiftadd_mul_chk.sv
module shiftadd_mul_chk #(
    parameter int W = 8
) (
    input logic           clk_i,
    input logic           rst_ni,
    input logic           start_i,
    input logic [W-1:0]   mcand_i,
    input logic [W-1:0]   mplier_i,
    input logic           busy_o,
    input logic           done_o,
    input logic [2*W-1:0] product_o
);

    logic [15:0]  cyc_q;
    logic [W-1:0] ea_q, eb_q;
    logic         accept;

    assign accept = start_i && !busy_o;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cyc_q <= '0;
            ea_q  <= '0;
            eb_q  <= '0;
        end else if (accept) begin
            cyc_q <= '0;
            ea_q  <= mcand_i;
            eb_q  <= mplier_i;
        end else if (busy_o) begin
            cyc_q <= cyc_q + 16'd1;
        end
    end

    assert_accept_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept |=> busy_o);

    assert_product_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> product_o == ((2*W)'(ea_q) * (2*W)'(eb_q)));

    assert_latency_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> cyc_q == 16'(2 * W));

    assert_busy_until_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |=> (busy_o || done_o));

    assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    assert_done_not_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(done_o && busy_o));

    assert_product_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && !$past(busy_o)) |-> $stable(product_o));

endmodule

bind shiftadd_mul shiftadd_mul_chk #(.W(W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .mcand_i   (mcand_i),
    .mplier_i  (mplier_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .product_o (product_o)
);

// File: tb/shiftadd_mul_test.sv
`timescale 1ns/1ps
module shiftadd_mul_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        st8 = 1'b0, bz8, dn8;
    logic [7:0]  a8 = '0, b8 = '0;
    logic [15:0] p8;
    logic        st4 = 1'b0, bz4, dn4;
    logic [3:0]  a4 = '0, b4 = '0;
    logic [7:0]  p4;

    int checks = 0;
    int fails  = 0;

    shiftadd_mul #(.W(8)) uut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(st8), .mcand_i(a8), .mplier_i(b8),
        .busy_o(bz8), .done_o(dn8), .product_o(p8));

    shiftadd_mul #(.W(4)) uut_w4 (
        .clk_i(clk), .rst_ni(rst_n), .start_i(st4), .mcand_i(a4), .mplier_i(b4),
        .busy_o(bz4), .done_o(dn4), .product_o(p4));

    task automatic check(input bit ok, input string rq, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // start one 8-bit multiply, wait for done; returns negedges counted from accepting edge
    task automatic mul8(input logic [7:0] a, input logic [7:0] b, input string rq);
        int k;
        @(negedge clk); st8 = 1'b1; a8 = a; b8 = b;
        @(negedge clk); st8 = 1'b0; k = 1;
        check(bz8 == 1'b1, "R2 busy after accept", bz8, 1);
        while (!dn8 && k < 100) begin @(negedge clk); k++; end
        check(k == 17, "R4 latency", k, 17);
        check(p8 == 16'(a) * 16'(b), rq, p8, 16'(a) * 16'(b));
    endtask

    task automatic mul4(input logic [3:0] a, input logic [3:0] b, input string rq);
        int k;
        @(negedge clk); st4 = 1'b1; a4 = a; b4 = b;
        @(negedge clk); st4 = 1'b0; k = 1;
        while (!dn4 && k < 100) begin @(negedge clk); k++; end
        check(k == 9, "R4 latency W4", k, 9);
        check(p4 == 8'(a) * 8'(b), rq, p4, 8'(a) * 8'(b));
    endtask

    task automatic t_reset;
        check(bz8 == 0 && dn8 == 0, "R1 flags W8", {bz8, dn8}, 0);
        check(p8 == 0, "R1 product W8", p8, 0);
        check(bz4 == 0 && dn4 == 0 && p4 == 0, "R1 W4", {bz4, dn4, p4}, 0);
    endtask

    task automatic t_example;
        mul4(4'b1011, 4'b1101, "R9 11x13");
        check(p4 == 8'b10001111, "R9 pattern", p4, 143);
    endtask

    task automatic t_exhaustive4;
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++)
                mul4(4'(i), 4'(j), "R3 exhaustive W4");
    endtask

    task automatic t_corners;
        mul8(8'hFF, 8'hFF, "R8 all ones");
        mul8(8'h00, 8'hA5, "R8 zero mcand");
        mul8(8'h5A, 8'h00, "R8 zero mplier");
        mul8(8'h80, 8'hFF, "R8 carry");
        @(negedge clk);
        check(dn8 == 0 && bz8 == 0, "R5 pulse end", {dn8, bz8}, 0);
    endtask

    task automatic t_random;
        for (int n = 0; n < 200; n++)
            mul8(8'($urandom), 8'($urandom), "R3 random W8");
    endtask

    task automatic t_start_ignored;
        int k;
        @(negedge clk); st8 = 1'b1; a8 = 8'd200; b8 = 8'd123;
        @(negedge clk); st8 = 1'b0; k = 1;
        @(negedge clk); k++;
        @(negedge clk); k++; st8 = 1'b1; a8 = 8'd3; b8 = 8'd5;
        @(negedge clk); k++; st8 = 1'b0;
        while (!dn8 && k < 100) begin @(negedge clk); k++; end
        check(k == 17, "R6 timing kept", k, 17);
        check(p8 == 16'd24600, "R6 result kept", p8, 24600);
    endtask

    task automatic t_hold;
        logic [15:0] held;
        mul8(8'd77, 8'd91, "R3 before hold");
        held = p8;
        @(negedge clk); a8 = 8'h12; b8 = 8'h34;
        for (int n = 0; n < 6; n++) @(negedge clk);
        check(p8 == held, "R7 product held", p8, held);
        check(bz8 == 0 && dn8 == 0, "R7 stays idle", {bz8, dn8}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_example();
        t_exhaustive4();
        t_corners();
        t_start_ignored();
        t_hold();
        t_random();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule